// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a two-wire serial slave that only accepts writes. A bus master sends a fixed frame of ten bytes: an address byte, two header bytes whose values the block ignores, and then seven payload bytes. Each payload byte goes into one of seven 8-bit configuration registers. The block never returns data. Its only drive onto the data line is an active-low acknowledge in the ninth clock of each byte. It gives that acknowledge only when the frame was addressed to it.

Both serial lines are brought into the system clock domain through a synchronizer. Start, stop and clock edges are found from the synchronized levels. The registers hold programmable defaults from reset, so a system that never uses the bus still sees valid settings. A payload byte is written to its register as soon as its eighth bit arrives. A frame that is cut short therefore keeps the bytes it has already delivered.

Top module: `cfgrx_top`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, every register returns to its byte of `DEFAULT_CFG` and `sda_pull_low` is 0.
- R2: A start (data line falling while the clock line is high) begins a new frame at any point. The next byte is treated as the address byte, even in the middle of a frame.
- R3: Bits are sampled on rising edges of the serial clock, most significant bit first. Eight data clocks make a byte, and a ninth clock follows it for the acknowledge.
- R4: The address byte must equal 8'hD2, which is the 7-bit address 7'h69 followed by a 0 write bit. Any other value, including 8'hD3, leaves every register unchanged for the whole frame.
- R5: In a matched frame, `sda_pull_low` is 1 throughout the ninth clock of every byte, starting with the address byte. In a frame whose address did not match, it stays 0. It is never 1 while the serial clock is high and no acknowledge is due.
- R6: Frame bytes 2 and 3 (command and count) may take any value and never change a register.
- R7: Frame bytes 4 to 10 load registers 0 to 6 in that order. Register k appears on `cfg_regs[8k+7:8k]`.
- R8: A payload byte is committed once its eighth bit is received. A stop later in the frame keeps it, and registers whose bytes never arrived keep their old values.
- R9: Bytes after the tenth are acknowledged in a matched frame, but they are discarded.
- R10: A stop (data line rising while the clock line is high) ends the frame. Clock pulses that arrive before the next start are ignored and get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_regs | output | 56 | Seven configuration registers, register k in bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: seven registers, address 7'h69, three header positions and a two-stage synchronizer. It drives the bus with eight system clocks per bus phase. At that rate the three-cycle synchronizer and edge-detect lag stays well inside each bus phase. With seven registers, one random frame of up to thirteen bytes can reach every register slot and the discarded tail after it. Directed cases cover a repeated start, the write bit set in the address, early stops and clocking without a start.

// File: rtl/cfgrx_pkg.sv
// Shared types for the serial configuration receiver.
package cfgrx_pkg;
    // Bus state as seen by the frame sequencer.
    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } frame_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/cfgrx_sync.sv
// Brings the two serial lines into the clk domain through a flop chain and
// derives clock edges plus start and stop conditions from synchronized levels.
// Assumes each bus phase lasts several clk cycles; idle bus lines are high.
module cfgrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First synchronizer stage samples the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[0] <= 1'b1;
                    sda_ff[0] <= 1'b1;
                end else begin
                    scl_ff[0] <= scl_in;
                    sda_ff[0] <= sda_in;
                end
            end
        end else begin : g_next
            // Later stages pass the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff[s] <= 1'b1;
                    sda_ff[s] <= 1'b1;
                end else begin
                    scl_ff[s] <= scl_ff[s-1];
                    sda_ff[s] <= sda_ff[s-1];
                end
            end
        end
    end

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Decode edges and bus conditions from the current and previous levels.
    always_comb begin
        scl_rise   = scl_lvl & ~scl_q;
        scl_fall   = ~scl_lvl & scl_q;
        start_cond = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_cond  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/cfgrx_frame.sv
// Frame sequencer: shifts in bits, counts bits and bytes, compares the address
// byte and drives the acknowledge in the ninth clock of each byte.
// Assumes edge and condition strobes are single-cycle pulses in the clk domain.
module cfgrx_frame
    import cfgrx_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h69,
    parameter int         IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_data,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              addr_ok,
    output logic              ack_low
);
    localparam logic [7:0]       ADDR_WR = {ADDR7, 1'b0};
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    frame_state_t         state;
    logic [3:0]           bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic [IDX_W-1:0]     next_idx;
    logic [BYTE_W-1:0]    shifted;

    assign shifted   = {shreg[BYTE_W-2:0], sda_lvl};
    assign byte_data = shreg;

    // Track frame state, bit position, byte position, match flag and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FR_IDLE;
            bit_cnt   <= 4'd0;
            shreg     <= '0;
            next_idx  <= '0;
            byte_idx  <= '0;
            byte_done <= 1'b0;
            addr_ok   <= 1'b0;
            ack_low   <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start_cond) begin
                state    <= FR_ACTIVE;
                bit_cnt  <= 4'd0;
                next_idx <= '0;
                addr_ok  <= 1'b0;
                ack_low  <= 1'b0;
            end else if (stop_cond) begin
                state   <= FR_IDLE;
                bit_cnt <= 4'd0;
                ack_low <= 1'b0;
            end else if (state == FR_ACTIVE) begin
                if (scl_rise) begin
                    if (bit_cnt < 4'd8) begin
                        shreg   <= shifted;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            byte_done <= 1'b1;
                            byte_idx  <= next_idx;
                            if (next_idx == '0) begin
                                addr_ok <= (shifted == ADDR_WR);
                            end
                            if (next_idx != IDX_MAX) begin
                                next_idx <= next_idx + 1'b1;
                            end
                        end
                    end else if (bit_cnt == 4'd8) begin
                        bit_cnt <= 4'd9;
                    end
                end else if (scl_fall) begin
                    if (bit_cnt == 4'd8) begin
                        ack_low <= addr_ok;
                    end else if (bit_cnt == 4'd9) begin
                        ack_low <= 1'b0;
                        bit_cnt <= 4'd0;
                    end
                end
            end
        end
    end

    assert_ack_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_low |-> addr_ok);
    assert_ack_rises_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_low) |-> !scl_lvl);
    assert_bit_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd9);
    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |-> !ack_low);
endmodule

// File: rtl/cfgrx_regs.sv
// Configuration register bank: holds defaults from reset and loads a received
// byte into the slot matching its frame position when the address matched.
// Assumes byte_done is a one-cycle strobe with byte_idx and byte_data valid.
module cfgrx_regs #(
    parameter int                       NUM_REGS    = 7,
    parameter int                       HDR_BYTES   = 3,
    parameter int                       IDX_W       = 5,
    parameter logic [NUM_REGS*8-1:0]    DEFAULT_CFG = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_done,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [7:0]              byte_data,
    input  logic                    addr_ok,
    output logic [NUM_REGS*8-1:0]   cfg_q
);
    localparam logic [IDX_W-1:0] FIRST_SLOT = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] END_SLOT   = IDX_W'(HDR_BYTES + NUM_REGS);

    logic wr_ok;
    assign wr_ok = byte_done & addr_ok;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(HDR_BYTES + k);
        // Load default on reset, else take the payload byte aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[k*8 +: 8] <= DEFAULT_CFG[k*8 +: 8];
            end else if (wr_ok && byte_idx == SLOT) begin
                cfg_q[k*8 +: 8] <= byte_data;
            end
        end
    end

    assert_no_write_unmatched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |=> $stable(cfg_q));
    assert_header_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_idx < FIRST_SLOT) |=> $stable(cfg_q));
    assert_tail_discarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_idx >= END_SLOT) |=> $stable(cfg_q));
endmodule

// File: rtl/cfgrx_top.sv
// Write-only serial configuration receiver top: synchronizer, frame sequencer
// and register bank. Assumes the bus runs well below the clk rate.
module cfgrx_top #(
    parameter int                    NUM_REGS    = 7,
    parameter int                    HDR_BYTES   = 3,
    parameter logic [6:0]            ADDR7       = 7'h69,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] DEFAULT_CFG = 56'hF0_0F_55_AA_3C_81_A5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull_low,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int IDX_W = $clog2(HDR_BYTES + NUM_REGS + 1) + 1;

    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_cond, stop_cond;
    logic             byte_done, addr_ok;
    logic [7:0]       byte_data;
    logic [IDX_W-1:0] byte_idx;

    cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_cond(start_cond), .stop_cond(stop_cond)
    );

    cfgrx_frame #(.ADDR7(ADDR7), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_cond(start_cond),
        .stop_cond(stop_cond), .byte_done(byte_done), .byte_data(byte_data),
        .byte_idx(byte_idx), .addr_ok(addr_ok), .ack_low(sda_pull_low)
    );

    cfgrx_regs #(
        .NUM_REGS(NUM_REGS), .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W),
        .DEFAULT_CFG(DEFAULT_CFG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_idx(byte_idx),
        .byte_data(byte_data), .addr_ok(addr_ok), .cfg_q(cfg_regs)
    );
endmodule

// File: tb/tb_cfgrx_top.sv
// Bench for cfgrx_top: a bus master model with a reference register image.
module tb_cfgrx_top;
    localparam int         NREG  = 7;
    localparam int         HALF  = 8;
    localparam logic [55:0] DEFS = 56'hF0_0F_55_AA_3C_81_A5;
    localparam logic [7:0] ADDR_BYTE = 8'hD2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull_low;
    logic [55:0] cfg_regs;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] expv [0:NREG-1];
    logic [7:0] fbuf [0:15];

    assign sda_line = sda_m & ~sda_pull_low;

    always #2.5 clk = ~clk;

    cfgrx_top #(.DEFAULT_CFG(DEFS)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .cfg_regs(cfg_regs)
    );

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        logic bad = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (cfg_regs[k*8 +: 8] !== expv[k]) bad = 1'b1;
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s regs got %h exp %h_%h_%h_%h_%h_%h_%h", req, cfg_regs,
                     expv[6], expv[5], expv[4], expv[3], expv[2], expv[1], expv[0]);
        end
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_half();
        scl_m = 1'b1; wait_half();
        sda_m = 1'b0; wait_half();
        scl_m = 1'b0; wait_half();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_half();
        scl_m = 1'b1; wait_half();
        sda_m = 1'b1; wait_half();
    endtask

    // Send eight bits MSB first and check the ninth-clock acknowledge.
    task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                             input int pos, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_half();
            scl_m = 1'b1; wait_half();
            scl_m = 1'b0; wait_half();
        end
        sda_m = 1'b1; wait_half();
        scl_m = 1'b1;
        repeat (HALF/2) @(negedge clk);
        checks++;
        if ((!sda_line) !== exp_ack) begin
            errors++;
            $display("FAIL %s ack at byte %0d got %0b exp %0b", req, pos, !sda_line, exp_ack);
        end
        repeat (HALF/2) @(negedge clk);
        scl_m = 1'b0; wait_half();
    endtask

    // Send fbuf[0..n-1] after a start, update the reference, optional stop.
    task automatic run_frame(input int n, input logic with_stop, input string req);
        logic match = (fbuf[0] == ADDR_BYTE);
        do_start();
        for (int p = 0; p < n; p++) begin
            send_byte(fbuf[p], match, p, req);
            if (match && p >= 3 && p < 3 + NREG) expv[p-3] = fbuf[p];
        end
        if (with_stop) do_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int k = 0; k < NREG; k++) expv[k] = DEFS[k*8 +: 8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: defaults after reset and no acknowledge.
        check_regs("R1");
        checks++;
        if (sda_pull_low !== 1'b0) begin
            errors++;
            $display("FAIL R1 sda_pull_low got %0b exp 0", sda_pull_low);
        end

        // R7/R3: full matched frame, asymmetric data, MSB first.
        fbuf[0] = ADDR_BYTE; fbuf[1] = 8'h00; fbuf[2] = 8'h07;
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'h01 << k | 8'h10;
        run_frame(10, 1'b1, "R7");
        check_regs("R7");

        // R6: arbitrary command and count values.
        fbuf[1] = 8'hFF; fbuf[2] = 8'h5A;
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'hC0 + 8'(k);
        run_frame(10, 1'b1, "R6");
        check_regs("R6");

        // R4: write bit set in address, then a plain wrong address.
        fbuf[0] = 8'hD3;
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'h33;
        run_frame(10, 1'b1, "R4");
        check_regs("R4");
        fbuf[0] = 8'hD0;
        run_frame(10, 1'b1, "R4");
        check_regs("R4");

        // R8: stop after data byte 2; bytes 0..2 committed, rest kept.
        fbuf[0] = ADDR_BYTE;
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'h90 + 8'(k);
        run_frame(6, 1'b1, "R8");
        check_regs("R8");

        // R9: thirteen bytes, tail acknowledged and discarded.
        for (int k = 0; k < 6; k++) fbuf[10+k] = 8'hEE;
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'h60 + 8'(k);
        run_frame(13, 1'b1, "R9");
        check_regs("R9");

        // R2: repeated start mid-frame restarts byte positions.
        fbuf[0] = ADDR_BYTE; fbuf[1] = 8'h00; fbuf[2] = 8'h00;
        run_frame(3, 1'b0, "R2");
        for (int k = 0; k < NREG; k++) fbuf[3+k] = 8'h21 + 8'(k);
        run_frame(10, 1'b1, "R2");
        check_regs("R2");
        // R2: restart with wrong address drops the partial matched frame.
        run_frame(2, 1'b0, "R2");
        fbuf[0] = 8'h4C;
        run_frame(10, 1'b1, "R2");
        check_regs("R2");

        // R10: clocking after a stop without a start is ignored.
        fbuf[0] = ADDR_BYTE;
        for (int p = 0; p < 12; p++) send_byte((p == 0) ? ADDR_BYTE : 8'h77, 1'b0, p, "R10");
        check_regs("R10");

        // R5/R7/R4: random frames, lengths and addresses.
        for (int f = 0; f < 36; f++) begin
            int n = 1 + int'($urandom % 13);
            logic st = ($urandom % 4) != 0;
            fbuf[0] = (($urandom % 4) != 0) ? ADDR_BYTE : 8'($urandom);
            for (int p = 1; p < 16; p++) fbuf[p] = 8'($urandom);
            run_frame(n, st, "R5");
            check_regs("R7");
        end
        do_stop();
        check_regs("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule